// File: doc/BRIEF.md
# Fixed-Point Sample ALU with Programmable Multiply Radix

This block is the arithmetic core of a small sample-processing engine. It is a single-cycle combinational unit: two signed 24-bit operands and a 4-bit function code go in, and a 24-bit result comes out in the same cycle. The functions cover addition and subtraction, signed comparisons, bitwise logic, an arithmetic right shift, a fixed-point multiply and a clip that is symmetric about zero.

The only state is a small radix register, which sets where the binary point of a multiply lands. A program writes it once with a dedicated function code. After that, every multiply is scaled by it. The intended uses are interpolation and gain stages on audio samples, where a product must be brought back to sample scale. The clip then bounds the result to ±B.

Results of add, subtract and multiply wrap. No overflow flag is produced.

Top module: `fxp_alu`

## Requirements
- R1: Function 1h returns A unchanged, and function 2h returns B unchanged.
- R2: Function 3h returns A+B and function 4h returns A−B. Both wrap modulo 2^24.
- R3: Function 5h forms the full 48-bit signed product A×B, shifts it arithmetically right by the current radix value, and returns the low 24 bits.
- R4: The 5-bit radix register resets to 0. On a rising clock edge it loads B[4:0] when `en` is 1 and function 0h is selected. In every other case it holds its value.
- R5: While function 0h is selected, the result equals B, whatever the value of `en`.
- R6: Function 6h shifts A arithmetically right by B[4:0]. B[23:5] has no effect. A shift amount of 24 to 31 gives 24 copies of A's sign bit.
- R7: Functions 7h (A==B), 8h (A<B), 9h (A>B) and Ah (A!=B) compare A and B as signed values. Each returns 24'd1 when the comparison holds and 24'd0 when it does not.
- R8: Function Bh returns A AND B, Ch returns NOT A, Dh returns A XOR B and Eh returns A OR B, all bitwise.
- R9: Function Fh returns B when A > B. Otherwise it returns −B when A < −B, and otherwise it returns A. The comparisons are signed and −B is formed without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the radix register |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Qualifies a radix load when function 0h is selected |
| func | input | 4 | Function code |
| opa | input | 24 | Operand A, two's complement |
| opb | input | 24 | Operand B, two's complement |
| result | output | 24 | Combinational result |

## Verification
The assertions assume that `func`, `opa` and `opb` are known and stable around each rising edge, and that `en` matters only for the radix load. The bench meets this by changing every input on the falling edge and sampling one time step later.

The clip bound is asserted only for a non-negative B, because for a negative B the ±B window is inverted. The directed stimulus covers both cases and checks the inverted case against the ordered rule in R9.

Radix loads are driven only through function 0h with `en` high. The hold property is also exercised by function 0h with `en` low, and by other functions with `en` high.

// File: rtl/fxp_alu_pkg.sv
package fxp_alu_pkg;

   typedef enum logic [3:0] {
      FN_RADIX = 4'h0,
      FN_PASSA = 4'h1,
      FN_PASSB = 4'h2,
      FN_ADD   = 4'h3,
      FN_SUB   = 4'h4,
      FN_MUL   = 4'h5,
      FN_SHR   = 4'h6,
      FN_EQ    = 4'h7,
      FN_LT    = 4'h8,
      FN_GT    = 4'h9,
      FN_NE    = 4'hA,
      FN_AND   = 4'hB,
      FN_NOT   = 4'hC,
      FN_XOR   = 4'hD,
      FN_OR    = 4'hE,
      FN_CLIP  = 4'hF
   } fxp_fn_e;

endpackage

// File: rtl/fxp_radix_reg.sv
module fxp_radix_reg #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [RW-1:0] din,
   output logic [RW-1:0] radix
);

   generate
      if (RW < 1) begin : g_bad_rw
         $error("fxp_radix_reg: RW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) radix <= '0;
      else if (load) radix <= din;
   end

   assert_radix_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> radix == $past(din));

   assert_radix_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(radix));

endmodule

// File: rtl/fxp_mul.sv
module fxp_mul #(
   parameter int DW = 24,
   parameter int RW = 5
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [RW-1:0] radix,
   output logic [DW-1:0] y
);

   localparam int PW = 2 * DW;

   generate
      if ((1 << RW) > PW) begin : g_bad_radix
         $error("fxp_mul: radix range exceeds product width");
      end
   endgenerate

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] scaled;

   always_comb begin
      prod   = PW'($signed(a)) * PW'($signed(b));
      scaled = prod >>> radix;
      y      = scaled[DW-1:0];
   end

endmodule

// File: rtl/fxp_shr.sv
module fxp_shr #(
   parameter int DW        = 24,
   parameter int SW        = 5,
   parameter bit LOG_STAGE = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [SW-1:0] amt,
   output logic [DW-1:0] y
);

   generate
      if (SW < 1 || SW > 16) begin : g_bad_sw
         $error("fxp_shr: SW out of range");
      end

      if (LOG_STAGE) begin : g_log
         logic [DW-1:0] stg [0:SW];
         assign stg[0] = a;
         for (genvar i = 0; i < SW; i++) begin : g_stage
            localparam int STEP = 1 << i;
            logic [DW-1:0] moved;
            if (STEP >= DW) begin : g_fill
               assign moved = {DW{stg[i][DW-1]}};
            end else begin : g_part
               assign moved = {{STEP{stg[i][DW-1]}}, stg[i][DW-1:STEP]};
            end
            assign stg[i+1] = amt[i] ? moved : stg[i];
         end
         assign y = stg[SW];
      end else begin : g_flat
         assign y = $signed(a) >>> amt;
      end
   endgenerate

endmodule

// File: rtl/fxp_clip.sv
module fxp_clip #(
   parameter int DW = 24
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);

   localparam int EW = DW + 1;

   logic signed [EW-1:0] ae, be, nbe;

   always_comb begin
      ae  = {a[DW-1], a};
      be  = {b[DW-1], b};
      nbe = -be;
      if (ae > be)       y = b;
      else if (ae < nbe) y = nbe[DW-1:0];
      else               y = a;
   end

endmodule

// File: rtl/fxp_alu.sv
module fxp_alu #(
   parameter int DW        = 24,
   parameter int RW        = 5,
   parameter int SW        = 5,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [3:0]    func,
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   output logic [DW-1:0] result
);

   import fxp_alu_pkg::*;

   localparam int MINW = (RW > SW) ? RW : SW;

   generate
      if (DW < MINW + 1) begin : g_bad_dw
         $error("fxp_alu: DW too small for radix and shift fields");
      end
   endgenerate

   fxp_fn_e        fn;
   logic [RW-1:0]  radix;
   logic [DW-1:0]  mul_y, shr_y, clip_y;
   logic           flag;
   logic           is_cmp;

   assign fn = fxp_fn_e'(func);

   fxp_radix_reg #(.RW(RW)) u_radix (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (en && fn == FN_RADIX),
      .din   (opb[RW-1:0]),
      .radix (radix)
   );

   fxp_mul #(.DW(DW), .RW(RW)) u_mul (
      .a     (opa),
      .b     (opb),
      .radix (radix),
      .y     (mul_y)
   );

   fxp_shr #(.DW(DW), .SW(SW), .LOG_STAGE(LOG_SHIFT)) u_shr (
      .a   (opa),
      .amt (opb[SW-1:0]),
      .y   (shr_y)
   );

   fxp_clip #(.DW(DW)) u_clip (
      .a (opa),
      .b (opb),
      .y (clip_y)
   );

   always_comb begin
      unique case (fn)
         FN_EQ:   flag = (opa == opb);
         FN_LT:   flag = ($signed(opa) < $signed(opb));
         FN_GT:   flag = ($signed(opa) > $signed(opb));
         FN_NE:   flag = (opa != opb);
         default: flag = 1'b0;
      endcase
   end

   assign is_cmp = (fn == FN_EQ) || (fn == FN_LT) || (fn == FN_GT) || (fn == FN_NE);

   always_comb begin
      unique case (fn)
         FN_RADIX: result = opb;
         FN_PASSA: result = opa;
         FN_PASSB: result = opb;
         FN_ADD:   result = opa + opb;
         FN_SUB:   result = opa - opb;
         FN_MUL:   result = mul_y;
         FN_SHR:   result = shr_y;
         FN_AND:   result = opa & opb;
         FN_NOT:   result = ~opa;
         FN_XOR:   result = opa ^ opb;
         FN_OR:    result = opa | opb;
         FN_CLIP:  result = clip_y;
         default:  result = {{(DW-1){1'b0}}, flag};
      endcase
   end

   assert_radix_passb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fn == FN_RADIX |-> result == opb);

   assert_shift_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_SHR && int'(opb[SW-1:0]) >= DW) |-> result == {DW{opa[DW-1]}});

   assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmp |-> result[DW-1:1] == '0);

   assert_clip_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_CLIP && !opb[DW-1]) |->
         ($signed(result) <= $signed(opb) && $signed(result) >= -$signed(opb)));

endmodule

// File: tb/fxp_alu_bench.sv
module fxp_alu_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [3:0]    func = 4'h1;
   logic [DW-1:0] opa = '0;
   logic [DW-1:0] opb = '0;
   logic [DW-1:0] result;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fxp_alu u_fxp_alu (
      .clk(clk), .rst_n(rst_n), .en(en), .func(func),
      .opa(opa), .opb(opb), .result(result)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] f, input logic [DW-1:0] a, input logic [DW-1:0] b);
      @(negedge clk);
      en = 1'b0; func = f; opa = a; opb = b;
      #1;
   endtask

   task automatic set_radix(input logic [4:0] r);
      @(negedge clk);
      en = 1'b1; func = 4'h0; opb = {19'h12345, r};
      @(posedge clk);
      #1;
      en = 1'b0;
   endtask

   function automatic logic [DW-1:0] m_mul(input logic [DW-1:0] a, input logic [DW-1:0] b, input int r);
      logic signed [47:0] p;
      p = 48'($signed(a)) * 48'($signed(b));
      p = p >>> r;
      return p[DW-1:0];
   endfunction

   function automatic logic [DW-1:0] m_clip(input logic [DW-1:0] a, input logic [DW-1:0] b);
      longint sa, sb;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      if (sa > sb) return b;
      if (sa < -sb) return DW'(-sb);
      return a;
   endfunction

   task automatic t_reset;
      apply(4'h5, 24'd3, 24'd5);
      chk("R4 radix resets to 0", result, 24'd15);
   endtask

   task automatic t_pass;
      apply(4'h1, 24'hABCDEF, 24'h123456);
      chk("R1 pass A", result, 24'hABCDEF);
      apply(4'h2, 24'hABCDEF, 24'h123456);
      chk("R1 pass B", result, 24'h123456);
   endtask

   task automatic t_addsub;
      apply(4'h3, 24'h7FFFFF, 24'd1);
      chk("R2 add wrap", result, 24'h800000);
      apply(4'h3, 24'hFFFFF6, 24'd4);
      chk("R2 add neg", result, 24'hFFFFFA);
      apply(4'h4, 24'h800000, 24'd1);
      chk("R2 sub wrap", result, 24'h7FFFFF);
      apply(4'h4, 24'd10, 24'd25);
      chk("R2 sub neg", result, 24'hFFFFF1);
   endtask

   task automatic t_radix_mul;
      set_radix(5'd0);
      apply(4'h5, 24'hFFFFFD, 24'd7);
      chk("R3 mul radix0 neg", result, m_mul(24'hFFFFFD, 24'd7, 0));
      set_radix(5'd8);
      apply(4'h5, 24'h001800, 24'h000280);
      chk("R3 mul radix8", result, m_mul(24'h001800, 24'h000280, 8));
      apply(4'h5, 24'hFF0000, 24'h004000);
      chk("R3 mul radix8 neg", result, m_mul(24'hFF0000, 24'h004000, 8));
      set_radix(5'd23);
      apply(4'h5, 24'h400000, 24'h600000);
      chk("R3 mul radix23 q-format", result, m_mul(24'h400000, 24'h600000, 23));
      set_radix(5'd31);
      apply(4'h5, 24'h7FFFFF, 24'h7FFFFF);
      chk("R3 mul radix31", result, m_mul(24'h7FFFFF, 24'h7FFFFF, 31));
   endtask

   task automatic t_radix_hold;
      set_radix(5'd4);
      @(negedge clk);
      en = 1'b0; func = 4'h0; opa = 24'd0; opb = 24'd9;
      #1;
      chk("R5 func0 passes B en=0", result, 24'd9);
      @(posedge clk); #1;
      @(negedge clk);
      en = 1'b1; func = 4'h3; opa = 24'd1; opb = 24'd2;
      @(posedge clk); #1;
      en = 1'b0;
      apply(4'h5, 24'd256, 24'd2);
      chk("R4 radix held", result, 24'd32);
      @(negedge clk);
      en = 1'b1; func = 4'h0; opb = 24'hFFFFE2;
      #1;
      chk("R5 func0 passes B en=1", result, 24'hFFFFE2);
      @(posedge clk); #1;
      en = 1'b0;
      apply(4'h5, 24'h100000, 24'd4);
      chk("R4 radix loads B[4:0]=2", result, 24'h100000);
   endtask

   task automatic t_shift;
      apply(4'h6, 24'hF00000, 24'd4);
      chk("R6 shr neg", result, 24'hFF0000);
      apply(4'h6, 24'h400000, 24'hFFFF03);
      chk("R6 upper B ignored", result, 24'h080000);
      apply(4'h6, 24'h812345, 24'd24);
      chk("R6 shr 24 neg fill", result, 24'hFFFFFF);
      apply(4'h6, 24'h7FFFFF, 24'd31);
      chk("R6 shr 31 pos fill", result, 24'h000000);
      apply(4'h6, 24'h800000, 24'd23);
      chk("R6 shr 23", result, 24'hFFFFFF);
   endtask

   task automatic t_cmp;
      apply(4'h7, 24'h000055, 24'h000055);
      chk("R7 eq true", result, 24'd1);
      apply(4'h7, 24'h000055, 24'h000056);
      chk("R7 eq false", result, 24'd0);
      apply(4'h8, 24'hFFFFFF, 24'd1);
      chk("R7 lt signed", result, 24'd1);
      apply(4'h9, 24'hFFFFFF, 24'd1);
      chk("R7 gt signed", result, 24'd0);
      apply(4'h9, 24'd1, 24'h800000);
      chk("R7 gt vs min", result, 24'd1);
      apply(4'hA, 24'd3, 24'd4);
      chk("R7 ne", result, 24'd1);
   endtask

   task automatic t_logic;
      apply(4'hB, 24'hF0F0F0, 24'hFF00FF);
      chk("R8 and", result, 24'hF000F0);
      apply(4'hC, 24'h0F0F00, 24'd0);
      chk("R8 not", result, 24'hF0F0FF);
      apply(4'hD, 24'hF0F0F0, 24'hFF00FF);
      chk("R8 xor", result, 24'h0FF00F);
      apply(4'hE, 24'hF0F0F0, 24'h0000FF);
      chk("R8 or", result, 24'hF0F0FF);
   endtask

   task automatic t_clip;
      apply(4'hF, 24'd500, 24'd100);
      chk("R9 clip high", result, 24'd100);
      apply(4'hF, 24'hFFFE0C, 24'd100);
      chk("R9 clip low", result, 24'hFFFF9C);
      apply(4'hF, 24'hFFFFCE, 24'd100);
      chk("R9 clip inside", result, 24'hFFFFCE);
      apply(4'hF, 24'hFFFFF6, 24'hFFFFFB);
      chk("R9 clip neg B", result, m_clip(24'hFFFFF6, 24'hFFFFFB));
      apply(4'hF, 24'd3, 24'hFFFFFB);
      chk("R9 clip neg B above", result, 24'hFFFFFB);
      apply(4'hF, 24'h800000, 24'h7FFFFF);
      chk("R9 clip min vs max", result, 24'h800001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_pass();
      t_addsub();
      t_radix_mul();
      t_radix_hold();
      t_shift();
      t_cmp();
      t_logic();
      t_clip();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule